// File: doc/BRIEF.md
# Translation Fault Status Register

This block is the 32-bit status word of an address-translation fault reporting unit. The fault logger drives event strobes into it, and the block keeps the flags that software inspects. Software reads the word, and clears flags by writing ones, through a small register port. The port decodes a single dword offset and returns read data one cycle after the request.

The central field is an advanced pending-fault flag. It sets when the logger writes fault record 0 while the flag is clear. A fault-record index is captured beside it whenever the logger reports the first pending fault. Both are sticky: only the power-good reset clears them, and the ordinary reset leaves them alone. A rising flag raises a one-cycle fault event request unless an external mask holds it back.

The three invalidation error flags are a build-time option. In the default build they read as zero.

Top module: `fault_status_reg`

## Requirements
- R1: A read request (`reg_rd`) at the dword address 34h (byte address bits above bit 1 match) returns the register word on `reg_rdata` in the following cycle; a read at any other address returns zero.
- R2: After power-good reset the word reads 00000000h, and bits 31:16, bit 7 and bits 2:0 always read zero, whatever is written.
- R3: Bit 3 (advanced pending fault) sets when `rec_wr` is high with `rec_idx` equal to 0 while the bit is clear; a record write with any other index leaves it unchanged.
- R4: A write at 34h with byte enable 0 set and data bit 3 equal to 1 clears bit 3; data bit 3 equal to 0, or byte enable 0 clear, leaves it unchanged.
- R5: When a clearing write and a setting record-0 write fall in the same cycle, bit 3 ends set.
- R6: Bit 3 and the index field keep their values through the ordinary reset `sys_rst`; only `pwr_rst` clears them.
- R7: Bits 15:8 load `pend_idx` when `pend_set` is high while `pend_flag` is low. They hold at all other times, including during software writes to the field.
- R8: `evt_req` is high for exactly one cycle, in the cycle after bit 3 goes from 0 to 1, and only if `int_mask` was low at that set; no pulse occurs while bit 3 stays set.
- R9: With invalidation error support disabled (default), bits 6:4 read zero even when the invalidation error inputs pulse.
- R10: Writes to any address other than 34h change nothing in the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| sys_rst | input | 1 | Ordinary synchronous reset, active high |
| pwr_rst | input | 1 | Power-good synchronous reset, active high, clears sticky state |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 32 | Write data |
| reg_be | input | 4 | Byte enables for the write |
| reg_rdata | output | 32 | Read data, one cycle after the read strobe |
| rec_wr | input | 1 | The fault logger wrote a fault record |
| rec_idx | input | IDX_W | Index of the record written |
| pend_set | input | 1 | The logger reports a pending fault |
| pend_idx | input | IDX_W | Record index of that pending fault |
| pend_flag | input | 1 | A pending fault is already flagged |
| inv_tmo_err | input | 1 | Invalidation completion time-out strobe |
| inv_cpl_err | input | 1 | Invalid invalidation completion strobe |
| inv_q_err | input | 1 | Invalidation queue error strobe |
| int_mask | input | 1 | Suppresses the fault event request |
| evt_req | output | 1 | One-cycle fault event request |

## Verification
The bench targets these corner cases:
- A clearing write and a record-0 write in the same cycle. A clear-priority flag would lose that fault.
- A clearing write that has byte enable 0 off, or that targets the next dword. A loose decode would wrongly drop the flag.
- An ordinary reset while the flag and the index are held. Wiring the wrong reset would wipe sticky state.
- A second `pend_set` that arrives while `pend_flag` is high. It must not overwrite the first index.
- Record writes while the flag is already set, and while `int_mask` is high. An edge detector built on the strobe rather than on the flag would raise a spurious event request in both cases.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
   localparam int WORD_W   = 32;
   localparam int BYTES_W  = WORD_W / 8;
   localparam int APF_POS  = 3;
   localparam int IQE_POS  = 4;
   localparam int ICE_POS  = 5;
   localparam int ITE_POS  = 6;
   localparam int IDX_LSB  = 8;
   localparam int IDX_MAXW = 8;
   typedef logic [WORD_W-1:0]  word_t;
   typedef logic [BYTES_W-1:0] be_t;
endpackage

// File: rtl/fsr_access_decode.sv
module fsr_access_decode
   import fsr_pkg::*;
#(
   parameter int          ADDR_W     = 8,
   parameter logic [31:0] REG_OFFSET = 32'h34
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   input  logic              rd,
   input  word_t             wdata,
   input  be_t               be,
   output logic              rd_hit,
   output word_t             w1c_mask
);
   localparam int DW_LSB = 2;

   if (ADDR_W <= DW_LSB) begin : g_bad_addr_w
      $error("ADDR_W must exceed the dword offset bits");
   end
   if (REG_OFFSET[DW_LSB-1:0] != '0) begin : g_bad_offset
      $error("REG_OFFSET must be dword aligned");
   end

   logic hit;
   assign hit    = (addr[ADDR_W-1:DW_LSB] == REG_OFFSET[ADDR_W-1:DW_LSB]);
   assign rd_hit = rd & hit;

   for (genvar b = 0; b < BYTES_W; b++) begin : g_lane
      assign w1c_mask[b*8 +: 8] = wdata[b*8 +: 8] & {8{wr & hit & be[b]}};
   end
endmodule

// File: rtl/fsr_sticky_w1c.sv
module fsr_sticky_w1c #(
   parameter bit STICKY = 1'b1
) (
   input  logic clk,
   input  logic sys_rst,
   input  logic pwr_rst,
   input  logic set,
   input  logic clr,
   output logic q,
   output logic rise
);
   logic hard_rst;

   if (STICKY) begin : g_powergood
      assign hard_rst = pwr_rst;
   end else begin : g_ordinary
      assign hard_rst = pwr_rst | sys_rst;
   end

   always_ff @(posedge clk) begin
      if (hard_rst) q <= 1'b0;
      else          q <= set | (q & ~clr);
   end

   assign rise = set & ~q;

   AST_SET_WINS: assert property (@(posedge clk) disable iff (hard_rst)
      set |=> q);                                              // R5
   AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (hard_rst)
      (q && clr && !set) |=> !q);                              // R4
   if (STICKY) begin : g_sticky_chk
      AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (pwr_rst)
         (sys_rst && q && !clr) |=> q);                        // R6
   end
endmodule

// File: rtl/fsr_index_capture.sv
module fsr_index_capture #(
   parameter int IDX_W = 8
) (
   input  logic             clk,
   input  logic             pwr_rst,
   input  logic             pend_set,
   input  logic             pend_flag,
   input  logic [IDX_W-1:0] pend_idx,
   output logic [IDX_W-1:0] idx_q
);
   logic cap;
   assign cap = pend_set & ~pend_flag;

   always_ff @(posedge clk) begin
      if (pwr_rst)  idx_q <= '0;
      else if (cap) idx_q <= pend_idx;
   end

   AST_IDX_HOLD: assert property (@(posedge clk) disable iff (pwr_rst)
      !cap |=> $stable(idx_q));                                // R7
   AST_IDX_LOAD: assert property (@(posedge clk) disable iff (pwr_rst)
      cap |=> (idx_q == $past(pend_idx)));                     // R7
endmodule

// File: rtl/fsr_event_pulse.sv
module fsr_event_pulse (
   input  logic clk,
   input  logic sys_rst,
   input  logic pwr_rst,
   input  logic rise,
   input  logic mask,
   output logic evt
);
   always_ff @(posedge clk) begin
      if (pwr_rst | sys_rst) evt <= 1'b0;
      else                   evt <= rise & ~mask;
   end

   AST_EVT_ONE_SHOT: assert property (@(posedge clk) disable iff (pwr_rst || sys_rst)
      evt |=> !evt);                                           // R8
   AST_EVT_MASKED: assert property (@(posedge clk) disable iff (pwr_rst || sys_rst)
      (rise && mask) |=> !evt);                                // R8
endmodule

// File: rtl/fault_status_reg.sv
module fault_status_reg
   import fsr_pkg::*;
#(
   parameter int          ADDR_W      = 8,
   parameter logic [31:0] REG_OFFSET  = 32'h34,
   parameter int          IDX_W       = 8,
   parameter bit          HAS_INV_ERR = 1'b0
) (
   input  logic              clk,
   input  logic              sys_rst,
   input  logic              pwr_rst,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [31:0]       reg_wdata,
   input  logic [3:0]        reg_be,
   output logic [31:0]       reg_rdata,
   input  logic              rec_wr,
   input  logic [IDX_W-1:0]  rec_idx,
   input  logic              pend_set,
   input  logic [IDX_W-1:0]  pend_idx,
   input  logic              pend_flag,
   input  logic              inv_tmo_err,
   input  logic              inv_cpl_err,
   input  logic              inv_q_err,
   input  logic              int_mask,
   output logic              evt_req
);
   if (IDX_W < 1 || IDX_W > IDX_MAXW) begin : g_bad_idx_w
      $error("IDX_W must lie in 1..8");
   end

   logic  rd_hit;
   word_t w1c_mask;
   logic  apf_q, apf_rise, apf_set;
   logic [IDX_W-1:0] idx_q;
   logic [2:0] inv_q;
   word_t rd_word;

   fsr_access_decode #(.ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET)) u_dec (
      .addr(reg_addr), .wr(reg_wr), .rd(reg_rd), .wdata(reg_wdata),
      .be(reg_be), .rd_hit(rd_hit), .w1c_mask(w1c_mask));

   assign apf_set = rec_wr & (rec_idx == '0);

   fsr_sticky_w1c #(.STICKY(1'b1)) u_apf (
      .clk(clk), .sys_rst(sys_rst), .pwr_rst(pwr_rst), .set(apf_set),
      .clr(w1c_mask[APF_POS]), .q(apf_q), .rise(apf_rise));

   fsr_index_capture #(.IDX_W(IDX_W)) u_idx (
      .clk(clk), .pwr_rst(pwr_rst), .pend_set(pend_set),
      .pend_flag(pend_flag), .pend_idx(pend_idx), .idx_q(idx_q));

   fsr_event_pulse u_evt (
      .clk(clk), .sys_rst(sys_rst), .pwr_rst(pwr_rst),
      .rise(apf_rise), .mask(int_mask), .evt(evt_req));

   if (HAS_INV_ERR) begin : g_inv
      logic [2:0] inv_set;
      logic [2:0] inv_rise_unused;
      assign inv_set = {inv_tmo_err, inv_cpl_err, inv_q_err};
      for (genvar k = 0; k < 3; k++) begin : g_flag
         fsr_sticky_w1c #(.STICKY(1'b0)) u_flag (
            .clk(clk), .sys_rst(sys_rst), .pwr_rst(pwr_rst),
            .set(inv_set[k]), .clr(w1c_mask[IQE_POS+k]),
            .q(inv_q[k]), .rise(inv_rise_unused[k]));
      end
   end else begin : g_no_inv
      logic unused_inv;
      assign unused_inv = inv_tmo_err ^ inv_cpl_err ^ inv_q_err;
      assign inv_q = 3'b000;
   end

   logic unused_mask;
   assign unused_mask = ^{w1c_mask[WORD_W-1:ITE_POS+1], w1c_mask[APF_POS-1:0]};

   always_comb begin
      rd_word = '0;
      rd_word[APF_POS] = apf_q;
      rd_word[ITE_POS:IQE_POS] = inv_q;
      rd_word[IDX_LSB +: IDX_W] = idx_q;
   end

   always_ff @(posedge clk) begin
      if (pwr_rst | sys_rst) reg_rdata <= '0;
      else                   reg_rdata <= rd_hit ? rd_word : '0;
   end

   AST_EVT_NEEDS_FLAG: assert property (@(posedge clk) disable iff (pwr_rst || sys_rst)
      evt_req |-> apf_q);                                      // R8
   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (pwr_rst || sys_rst)
      (reg_rdata[31:16] == '0) && !reg_rdata[7] && (reg_rdata[2:0] == '0)); // R2
   AST_MISS_READS_ZERO: assert property (@(posedge clk) disable iff (pwr_rst || sys_rst)
      !rd_hit |=> (reg_rdata == '0));                          // R1
endmodule

// File: tb/fault_status_reg_tb_top.sv
module fault_status_reg_tb_top;
   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic        sys_rst = 1'b1, pwr_rst = 1'b1;
   logic [7:0]  reg_addr = '0;
   logic        reg_wr = 0, reg_rd = 0;
   logic [31:0] reg_wdata = '0;
   logic [3:0]  reg_be = '0;
   logic [31:0] reg_rdata;
   logic        rec_wr = 0, pend_set = 0, pend_flag = 0;
   logic [7:0]  rec_idx = '0, pend_idx = '0;
   logic        inv_tmo_err = 0, inv_cpl_err = 0, inv_q_err = 0, int_mask = 0;
   logic        evt_req;

   fault_status_reg dut_i (
      .clk(clk), .sys_rst(sys_rst), .pwr_rst(pwr_rst), .reg_addr(reg_addr),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_be(reg_be),
      .reg_rdata(reg_rdata), .rec_wr(rec_wr), .rec_idx(rec_idx),
      .pend_set(pend_set), .pend_idx(pend_idx), .pend_flag(pend_flag),
      .inv_tmo_err(inv_tmo_err), .inv_cpl_err(inv_cpl_err), .inv_q_err(inv_q_err),
      .int_mask(int_mask), .evt_req(evt_req));

   int checks = 0, errors = 0;
   bit done = 0;

   typedef struct { logic [31:0] exp; string tag; } item_t;
   item_t exp_q[$];
   logic rd_seen = 0;
   always @(posedge clk) rd_seen <= reg_rd;

   // monitor: compares each read result one cycle after the request
   always @(negedge clk) begin
      if (rd_seen && exp_q.size() > 0) begin
         item_t it;
         it = exp_q.pop_front();
         checks++;
         if (reg_rdata !== it.exp) begin
            errors++;
            $display("FAIL %s: rdata=%08h expected=%08h", it.tag, reg_rdata, it.exp);
         end
      end
   end

   task automatic chk(input logic act, input logic exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
      end
   endtask

   // driver: issue a read and queue the expected word
   task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
      item_t it;
      @(negedge clk);
      reg_addr = a; reg_rd = 1;
      it.exp = e; it.tag = tag;
      exp_q.push_back(it);
      @(negedge clk);
      reg_rd = 0;
      @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_be = be; reg_wr = 1;
      @(negedge clk);
      reg_wr = 0;
   endtask

   task automatic hw_rec(input logic [7:0] idx);
      @(negedge clk);
      rec_wr = 1; rec_idx = idx;
      @(negedge clk);
      rec_wr = 0;
   endtask

   task automatic hw_pend(input logic [7:0] idx, input logic flag);
      @(negedge clk);
      pend_set = 1; pend_idx = idx; pend_flag = flag;
      @(negedge clk);
      pend_set = 0; pend_flag = 0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      sys_rst = 0; pwr_rst = 0;
      chk(evt_req, 1'b0, "R8 idle after reset");
      rd(8'h34, 32'h0, "R2 reset value");

      hw_rec(8'h05);
      chk(evt_req, 1'b0, "R3 non-zero index no event");
      rd(8'h34, 32'h0, "R3 non-zero index ignored");

      hw_rec(8'h00);
      chk(evt_req, 1'b1, "R8 pulse on set");
      @(negedge clk);
      chk(evt_req, 1'b0, "R8 pulse one cycle");
      rd(8'h34, 32'h8, "R3 record 0 sets flag");

      hw_rec(8'h00);
      chk(evt_req, 1'b0, "R8 no pulse while set");

      hw_pend(8'h2A, 1'b0);
      rd(8'h34, 32'h2A08, "R7 index captured");
      hw_pend(8'h11, 1'b1);
      rd(8'h34, 32'h2A08, "R7 index held while pending");

      wr(8'h34, 32'h0, 4'hF);
      rd(8'h34, 32'h2A08, "R4 write zero no effect");
      wr(8'h34, 32'h8, 4'hE);
      rd(8'h34, 32'h2A08, "R4 byte enable off no effect");
      wr(8'h38, 32'h8, 4'hF);
      rd(8'h34, 32'h2A08, "R10 other offset write ignored");
      rd(8'h38, 32'h0, "R1 other offset reads zero");
      rd(8'h37, 32'h2A08, "R1 byte address within dword");

      @(negedge clk);
      inv_tmo_err = 1; inv_cpl_err = 1; inv_q_err = 1;
      @(negedge clk);
      inv_tmo_err = 0; inv_cpl_err = 0; inv_q_err = 0;
      rd(8'h34, 32'h2A08, "R9 invalidation bits zero");
      wr(8'h34, 32'hFFFF_FFF7, 4'hF);
      rd(8'h34, 32'h2A08, "R2 reserved and index unwritable");

      @(negedge clk); sys_rst = 1;
      @(negedge clk); sys_rst = 0;
      rd(8'h34, 32'h2A08, "R6 sticky across ordinary reset");

      wr(8'h34, 32'h8, 4'h1);
      rd(8'h34, 32'h2A00, "R4 write one clears");

      int_mask = 1;
      hw_rec(8'h00);
      chk(evt_req, 1'b0, "R8 masked no pulse");
      int_mask = 0;
      rd(8'h34, 32'h2A08, "R3 set while masked");

      @(negedge clk);
      reg_addr = 8'h34; reg_wdata = 32'h8; reg_be = 4'h1; reg_wr = 1;
      rec_wr = 1; rec_idx = 8'h00;
      @(negedge clk);
      reg_wr = 0; rec_wr = 0;
      rd(8'h34, 32'h2A08, "R5 set wins over clear");

      wr(8'h34, 32'h8, 4'h1);
      @(negedge clk);
      reg_addr = 8'h34; reg_wdata = 32'h8; reg_be = 4'h1; reg_wr = 1;
      rec_wr = 1; rec_idx = 8'h00;
      @(negedge clk);
      reg_wr = 0; rec_wr = 0;
      chk(evt_req, 1'b1, "R5 R8 pulse when set beats clear");
      rd(8'h34, 32'h2A08, "R5 set wins from clear state");

      @(negedge clk); pwr_rst = 1;
      @(negedge clk); pwr_rst = 0;
      rd(8'h34, 32'h0, "R6 power-good reset clears");

      repeat (3) @(negedge clk);
      finish_run();
   end
endmodule